// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block decides which of several pending interrupt requests the CPU takes next. Every maskable source carries a 2-bit software level and an enable, both supplied by the surrounding registers. Its fixed hardware rank comes from its position: a lower source number means a higher rank. Two further sources, a reset-class request and a software trap, cannot be masked. Each request pulse sets a pending latch, and that latch holds until the source is serviced or a source-side clear strobe drops it.

Selection takes two steps. The highest software level among the eligible requests wins first, and hardware rank breaks any tie. A maskable request is eligible only while it is enabled and its level is strictly above the current running level. When a request wins, the block raises a one-cycle accept pulse together with the vector index. It saves the old running level on a small internal stack and raises the running level to the winner's level, or to 3 for a non-maskable source. The CPU acknowledges the vector to clear that pending latch, and a return strobe pops the saved level back. A registered wake flag tells the power controller that a request able to end halt mode is waiting.

Top module: `irq_nest_arb`

## Requirements
- R1: After the synchronous reset, take_vld, take_idx, run_lvl and wake are all 0, and nothing is pending.
- R2: A request that is not eligible when it arrives stays latched, and it is accepted as soon as the running level drops below its level.
- R3: Among eligible maskable requests, the one with the highest software level wins, whatever its source number.
- R4: Among eligible requests with equal software level, the lowest source number wins.
- R5: A maskable source is accepted only when its enable is 1 and its level is strictly greater than run_lvl. A request with level 0 is therefore never taken.
- R6: The reset-class request (index 0) and the trap (index 1) are accepted regardless of enables and run_lvl. Reset wins over trap, and either one sets run_lvl to 3.
- R7: An accept shows as take_vld high for exactly one cycle, one clock edge after the pending latch is set. take_idx is 2+i for maskable source i. No new accept happens until ack is asserted, and ack clears the accepted source's pending latch.
- R8: A clear strobe on a maskable source drops its pending latch, so that request is never accepted.
- R9: Each accept pushes the previous run_lvl onto a stack and sets run_lvl to the winner's level. A return strobe restores the most recent saved level, or 0 when the stack is empty.
- R10: wake rises one edge after any non-maskable request or any enabled maskable request is pending. A pending but disabled request does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| nmi_rst_req | input | 1 | Reset-class non-maskable request pulse |
| nmi_trap_req | input | 1 | Software trap request pulse |
| irq_req | input | N_SRC | Maskable request pulses, one per source |
| irq_en | input | N_SRC | Per-source enables |
| irq_lvl | input | N_SRC*2 | Software levels, source i at bits [2i+1:2i] |
| irq_clr | input | N_SRC | Source-side clear strobes |
| ack | input | 1 | CPU acknowledge of the accepted vector |
| reti | input | 1 | Return-from-interrupt strobe |
| take_vld | output | 1 | One-cycle accept pulse |
| take_idx | output | IDX_W | Index of the accepted vector |
| run_lvl | output | 2 | Current running level |
| wake | output | 1 | A halt-ending request is pending |

## Verification
A request pulse sampled at edge k sets its latch at that edge. The accept pulse, the new index, the raised run_lvl and wake all appear after edge k+1, so the bench checks them one edge after the latch edge and checks that take_vld is still low in between. An ack or return strobe acts at the edge that samples it. The bench reads run_lvl right after that edge, and it expects a re-enabled request to be accepted only one edge after a return. Every input changes 1 ns after a rising edge, and every output is read at that same point.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W   = 2;
  localparam int LVL_TOP = (1 << LVL_W) - 1;
  localparam int NMI_CNT = 2;   // index 0: reset-class, index 1: trap
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_TOT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_TOT-1:0] set_i,
  input  logic [N_TOT-1:0] clr_i,
  output logic [N_TOT-1:0] pend_o
);
  // Clear wins over a set in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (pend_o | set_i) & ~clr_i;
  end

  generate
    for (genvar g = 0; g < N_TOT; g++) begin : g_chk
      p_clr_drops_r8: assert property (@(posedge clk) disable iff (rst)
        clr_i[g] |=> !pend_o[g]);
    end
  endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 6,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC-1:0]       en_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  input  lvl_t                   run_i,
  output logic                   hit_o,
  output logic [IW-1:0]          idx_o,
  output lvl_t                   lvl_o
);
  // Descending scan with >= lets the lower index take an equal-level tie.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && en_i[i] && (lvl_i[i*LVL_W +: LVL_W] > run_i) &&
          (!hit_o || lvl_i[i*LVL_W +: LVL_W] >= lvl_o)) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
        lvl_o = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push_i,
  input  lvl_t push_d,
  input  logic pop_i,
  output lvl_t top_o,
  output logic empty_o
);
  lvl_t          mem [DEPTH];
  logic [CW-1:0] sp;

  assign empty_o = (sp == '0);
  assign top_o   = empty_o ? '0 : mem[PW'(sp - 1'b1)];

  // Storage carries no reset so it can map to distributed or block RAM.
  always_ff @(posedge clk) begin
    if (push_i && (sp < CW'(DEPTH))) mem[PW'(sp)] <= push_d;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (pop_i && !empty_o) sp <= sp - 1'b1;
    else if (push_i && (sp < CW'(DEPTH))) sp <= sp + 1'b1;
  end

  p_sp_bound_r9: assert property (@(posedge clk) disable iff (rst)
    sp <= CW'(DEPTH));
  p_pop_moves_r9: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !empty_o) |=> (sp == $past(sp) - 1'b1));
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_arb_pkg::*;
#(
  parameter int N_SRC       = 6,
  parameter int STACK_DEPTH = 4,
  localparam int N_TOT      = N_SRC + NMI_CNT,
  localparam int IDX_W      = $clog2(N_TOT),
  localparam int IW         = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   nmi_rst_req,
  input  logic                   nmi_trap_req,
  input  logic [N_SRC-1:0]       irq_req,
  input  logic [N_SRC-1:0]       irq_en,
  input  logic [N_SRC*LVL_W-1:0] irq_lvl,
  input  logic [N_SRC-1:0]       irq_clr,
  input  logic                   ack,
  input  logic                   reti,
  output logic                   take_vld,
  output logic [IDX_W-1:0]       take_idx,
  output logic [LVL_W-1:0]       run_lvl,
  output logic                   wake
);
  logic [N_TOT-1:0] pend, set_v, clr_v, ack_mask;
  logic             busy, hit, acc, nmi_any;
  logic [IW-1:0]    win_idx;
  lvl_t             win_lvl, top_lvl, new_lvl;
  logic [IDX_W-1:0] sel_idx;
  logic             stk_empty;

  assign set_v = {irq_req, nmi_trap_req, nmi_rst_req};

  always_comb begin
    ack_mask = '0;
    if (busy && ack) ack_mask[take_idx] = 1'b1;
  end
  assign clr_v = {irq_clr, 2'b00} | ack_mask;

  irq_pend_bank #(.N_TOT(N_TOT)) u_pend (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .pend_o(pend)
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .pend_i(pend[N_TOT-1:NMI_CNT]), .en_i(irq_en), .lvl_i(irq_lvl),
    .run_i(run_lvl), .hit_o(hit), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign nmi_any = pend[0] | pend[1];
  assign acc     = !busy && !reti && (nmi_any || hit);

  always_comb begin
    if (pend[0])      sel_idx = '0;
    else if (pend[1]) sel_idx = IDX_W'(1);
    else              sel_idx = IDX_W'(win_idx) + IDX_W'(NMI_CNT);
    new_lvl = nmi_any ? lvl_t'(LVL_TOP) : win_lvl;
  end

  irq_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push_i(acc), .push_d(run_lvl),
    .pop_i(reti), .top_o(top_lvl), .empty_o(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_vld <= 1'b0;
      take_idx <= '0;
      run_lvl  <= '0;
      busy     <= 1'b0;
      wake     <= 1'b0;
    end else begin
      take_vld <= acc;
      wake     <= nmi_any | (|(pend[N_TOT-1:NMI_CNT] & irq_en));
      if (acc) begin
        take_idx <= sel_idx;
        run_lvl  <= new_lvl;
        busy     <= 1'b1;
      end else begin
        if (reti) run_lvl <= stk_empty ? '0 : top_lvl;
        if (busy && ack) busy <= 1'b0;
      end
    end
  end

  p_pulse_one_r7: assert property (@(posedge clk) disable iff (rst)
    take_vld |=> !take_vld);
  p_wait_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack) |=> !take_vld);
  p_nmi_top_r6: assert property (@(posedge clk) disable iff (rst)
    (take_vld && (take_idx < IDX_W'(NMI_CNT))) |-> (run_lvl == lvl_t'(LVL_TOP)));
  p_strict_above_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && !nmi_any) |-> (win_lvl > run_lvl));
endmodule

// File: tb/irq_nest_arb_tb.sv
module irq_nest_arb_tb;
  localparam int N_SRC = 6;
  localparam int IDX_W = $clog2(N_SRC + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_rst_req = 1'b0, nmi_trap_req = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [N_SRC-1:0]   irq_req = '0, irq_en = '1, irq_clr = '0;
  logic [N_SRC*2-1:0] irq_lvl = '0;
  logic               take_vld, wake;
  logic [IDX_W-1:0]   take_idx;
  logic [1:0]         run_lvl;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_nest_arb #(.N_SRC(N_SRC)) u_dut (
    .clk(clk), .rst(rst), .nmi_rst_req(nmi_rst_req), .nmi_trap_req(nmi_trap_req),
    .irq_req(irq_req), .irq_en(irq_en), .irq_lvl(irq_lvl), .irq_clr(irq_clr),
    .ack(ack), .reti(reti), .take_vld(take_vld), .take_idx(take_idx),
    .run_lvl(run_lvl), .wake(wake)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_lvl(input int i, input int l);
    irq_lvl[i*2 +: 2] = 2'(l);
  endtask

  task automatic pulse_req(input int i);
    irq_req[i] = 1'b1; step(); irq_req[i] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; step(); reti = 1'b0;
  endtask

  task automatic expect_take(input string tag, input int idx, input int lvl);
    chk({tag, " take_vld"}, int'(take_vld), 1);
    chk({tag, " take_idx"}, int'(take_idx), idx);
    chk({tag, " run_lvl"}, int'(run_lvl), lvl);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0; step();
    chk("R1 take_vld", int'(take_vld), 0);
    chk("R1 take_idx", int'(take_idx), 0);
    chk("R1 run_lvl", int'(run_lvl), 0);
    chk("R1 wake", int'(wake), 0);
  endtask

  // R3, R4, R2: four requests at once, then served one by one on return.
  task automatic t_priority();
    set_lvl(0, 1); set_lvl(1, 3); set_lvl(2, 3); set_lvl(3, 2);
    irq_req[3:0] = 4'hF; step(); irq_req = '0;
    chk("R7 no take on latch edge", int'(take_vld), 0);
    step();
    expect_take("R4 tie to lower index", 3, 3);
    do_ack(); step();
    chk("R2 held while level 3", int'(take_vld), 0);
    do_reti();
    chk("R9 restore 0", int'(run_lvl), 0);
    step();
    expect_take("R2 latched level 3 taken", 4, 3);
    do_ack(); do_reti(); step();
    expect_take("R3 level 2 next", 5, 2);
    do_ack(); do_reti(); step();
    expect_take("R3 level 1 last", 2, 1);
    do_ack(); do_reti();
    chk("R7 ack cleared all", int'(wake), 0);
  endtask

  task automatic t_nest();
    set_lvl(4, 1); set_lvl(5, 2);
    pulse_req(4); step();
    expect_take("R9 first", 6, 1);
    do_ack();
    pulse_req(5); step();
    expect_take("R9 nested", 7, 2);
    do_ack();
    do_reti(); chk("R9 pop to 1", int'(run_lvl), 1);
    do_reti(); chk("R9 pop to 0", int'(run_lvl), 0);
    do_reti(); chk("R9 empty pop", int'(run_lvl), 0);
  endtask

  task automatic t_strict();
    set_lvl(3, 2); irq_en[3] = 1'b0;
    pulse_req(3); step();
    chk("R5 disabled not taken", int'(take_vld), 0);
    chk("R10 disabled no wake", int'(wake), 0);
    irq_en[3] = 1'b1; step();
    expect_take("R5 enabled taken", 5, 2);
    chk("R10 wake", int'(wake), 1);
    do_ack();
    set_lvl(4, 2); pulse_req(4); step();
    chk("R5 equal level blocked", int'(take_vld), 0);
    set_lvl(5, 3); pulse_req(5); step();
    expect_take("R5 above taken", 7, 3);
    do_ack();
    do_reti(); chk("R9 back to 2", int'(run_lvl), 2);
    step(); chk("R5 still equal", int'(take_vld), 0);
    do_reti(); chk("R9 back to 0", int'(run_lvl), 0);
    step();
    expect_take("R2 equal one later", 6, 2);
    do_ack(); do_reti();
    chk("R10 wake gone", int'(wake), 0);
  endtask

  task automatic t_nmi();
    set_lvl(1, 3); pulse_req(1); step();
    expect_take("R6 setup", 3, 3);
    do_ack();
    irq_en = '0;
    nmi_rst_req = 1'b1; nmi_trap_req = 1'b1; step();
    nmi_rst_req = 1'b0; nmi_trap_req = 1'b0; step();
    expect_take("R6 reset first", 0, 3);
    chk("R10 nmi wake", int'(wake), 1);
    do_ack(); step();
    expect_take("R6 trap next", 1, 3);
    do_ack();
    irq_en = '1;
    do_reti(); chk("R6 pop 3", int'(run_lvl), 3);
    do_reti(); chk("R6 pop 3 again", int'(run_lvl), 3);
    do_reti(); chk("R6 pop 0", int'(run_lvl), 0);
  endtask

  task automatic t_clear();
    set_lvl(2, 1); irq_en[2] = 1'b0;
    pulse_req(2);
    irq_clr[2] = 1'b1; step(); irq_clr[2] = 1'b0;
    irq_en[2] = 1'b1; step(); step();
    chk("R8 cleared not taken", int'(take_vld), 0);
    chk("R8 cleared no wake", int'(wake), 0);
    chk("R8 level unchanged", int'(run_lvl), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_priority();
    t_nest();
    t_strict();
    t_nmi();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule